// File: doc/BRIEF.md
# Condition Field Group Violation Checker

This block sits in the decode stage of a vector-capable core and inspects the condition-field operands of one instruction. Condition fields are numbered 0 to 127. Fields 0 to 7 make up the base group; fields 8 to 127 make up the extended group, which an implementation can then hold in a register file separate from the base fields. The checker enforces the rules that keep the two groups apart. When an instruction breaks a rule, it raises an illegal-instruction trap request together with a reason code, so that a violating instruction never executes silently.

Each operand slot carries a valid flag, a 7-bit field number and a vector flag. A single class input says whether the instruction has exactly one source and one destination, or more operands than that. The verdict is available combinationally in the same cycle. A registered copy is also provided: it is captured on a clock edge at which the instruction-valid strobe is high and reads zero after an edge at which the strobe is low.

Top module: `cf_group_check`

## Requirements
- R1: A field number belongs to the extended group when any of its bits 6:3 is set (fields 8 to 127), and to the base group otherwise (fields 0 to 7). Field 7 is base and field 8 is extended.
- R2: When multi_class is 1 (more than one source and one destination), the instruction traps with reason 2'b01 if its valid operands include at least one base field and at least one extended field.
- R3: When multi_class is 1 and every valid operand lies in a single group (for example vector fields 8, 16 and 40, or scalar fields 0 and 7), there is no trap.
- R4: When multi_class is 0 (exactly one source and one destination), the instruction traps with reason 2'b10 if any valid base-group operand has its vector flag set (for example a splat onto a vector that starts at field 0).
- R5: When multi_class is 0, mixing the groups is allowed. A scalar extended source written to a scalar base destination (field 40 into field 5) does not trap, and neither does a splat onto a vector that starts at an extended field.
- R6: An operand whose valid flag is 0 takes part in neither rule. An instruction with no valid operand never traps.
- R7: reason_now is 2'b00 for no trap, 2'b01 for a group cross-over and 2'b10 for a base field used as a vector. trap_now is 1 exactly when reason_now is not 2'b00. If both rules are met, the cross-over code wins.
- R8: At each rising clock edge, trap_q and reason_q take trap_now and reason_now when instr_valid is 1. They take 0 and 2'b00 when instr_valid is 0.
- R9: A synchronous active-high rst clears trap_q to 0 and reason_q to 2'b00 at the next rising edge, and this takes priority over instr_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction-valid strobe for the registered verdict |
| multi_class | input | 1 | 1 = more than one source and one destination, 0 = exactly one of each |
| opnd_valid | input | NUM_OPS | Per-operand: the slot holds a condition field |
| opnd_field | input | NUM_OPS*FIELD_W | Per-operand field number; slot i occupies bits [i*FIELD_W +: FIELD_W] |
| opnd_vector | input | NUM_OPS | Per-operand vector flag (1 = vector) |
| trap_now | output | 1 | Combinational trap request |
| reason_now | output | 2 | Combinational reason code |
| trap_q | output | 1 | Registered trap request |
| reason_q | output | 2 | Registered reason code |

## Verification
The combinational verdict is due in the same cycle as its operands. The bench drives each operand set on a falling edge and compares trap_now and reason_now one nanosecond later. The registered verdict is due one rising edge later. At every rising edge the bench latches the model value from rst, instr_valid and the operands that have been stable since the previous falling edge, and compares trap_q and reason_q two nanoseconds after that edge. The bench therefore never samples at the edge that updates the outputs.

// File: rtl/cf_group_pkg.sv
package cf_group_pkg;

    typedef enum logic [1:0] {
        CF_OK      = 2'b00,
        CF_XOVER   = 2'b01,
        CF_BASEVEC = 2'b10
    } cf_reason_e;

    typedef struct packed {
        logic       trap;
        cf_reason_e reason;
    } cf_verdict_s;

endpackage

// File: rtl/cf_field_class.sv
module cf_field_class #(
    parameter int HI_W = 4
) (
    input  logic            valid,
    input  logic            vector,
    input  logic [HI_W-1:0] field_hi,
    output logic            in_base,
    output logic            in_ext,
    output logic            base_vec
);
    logic upper_set;

    always_comb begin
        upper_set = |field_hi;
        in_ext    = valid & upper_set;
        in_base   = valid & ~upper_set;
        base_vec  = valid & ~upper_set & vector;
    end
endmodule

// File: rtl/cf_rule_eval.sv
module cf_rule_eval
    import cf_group_pkg::*;
#(
    parameter int NUM_OPS = 3
) (
    input  logic               multi_class,
    input  logic [NUM_OPS-1:0] in_base,
    input  logic [NUM_OPS-1:0] in_ext,
    input  logic [NUM_OPS-1:0] base_vec,
    output cf_reason_e         reason
);
    logic xover_hit;
    logic basevec_hit;

    always_comb begin
        xover_hit   = multi_class & (|in_base) & (|in_ext);
        basevec_hit = ~multi_class & (|base_vec);
        if (xover_hit) begin
            reason = CF_XOVER;
        end else if (basevec_hit) begin
            reason = CF_BASEVEC;
        end else begin
            reason = CF_OK;
        end
    end
endmodule

// File: rtl/cf_group_check.sv
module cf_group_check
    import cf_group_pkg::*;
#(
    parameter int NUM_OPS = 3,
    parameter int FIELD_W = 7,
    parameter int BASE_W  = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       instr_valid,
    input  logic                       multi_class,
    input  logic [NUM_OPS-1:0]         opnd_valid,
    input  logic [NUM_OPS*FIELD_W-1:0] opnd_field,
    input  logic [NUM_OPS-1:0]         opnd_vector,
    output logic                       trap_now,
    output logic [1:0]                 reason_now,
    output logic                       trap_q,
    output logic [1:0]                 reason_q
);
    localparam int HI_W = FIELD_W - BASE_W;

    logic [NUM_OPS-1:0] in_base;
    logic [NUM_OPS-1:0] in_ext;
    logic [NUM_OPS-1:0] base_vec;
    cf_reason_e         reason_c;
    cf_verdict_s        verdict_d;
    cf_verdict_s        verdict_q;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_opnd
        cf_field_class #(.HI_W(HI_W)) u_class (
            .valid    (opnd_valid[i]),
            .vector   (opnd_vector[i]),
            .field_hi (opnd_field[i*FIELD_W+BASE_W +: HI_W]),
            .in_base  (in_base[i]),
            .in_ext   (in_ext[i]),
            .base_vec (base_vec[i])
        );
    end

    cf_rule_eval #(.NUM_OPS(NUM_OPS)) u_rules (
        .multi_class (multi_class),
        .in_base     (in_base),
        .in_ext      (in_ext),
        .base_vec    (base_vec),
        .reason      (reason_c)
    );

    always_comb begin
        verdict_d = '0;
        if (instr_valid) begin
            verdict_d.trap   = (reason_c != CF_OK);
            verdict_d.reason = reason_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '0;
        end else begin
            verdict_q <= verdict_d;
        end
    end

    assign trap_now   = (reason_c != CF_OK);
    assign reason_now = reason_c;
    assign trap_q     = verdict_q.trap;
    assign reason_q   = verdict_q.reason;
endmodule

// File: rtl/cf_group_check_sva.sv
module cf_group_check_sva #(
    parameter int NUM_OPS = 3,
    parameter int FIELD_W = 7,
    parameter int BASE_W  = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       instr_valid,
    input logic                       multi_class,
    input logic [NUM_OPS-1:0]         opnd_valid,
    input logic [NUM_OPS*FIELD_W-1:0] opnd_field,
    input logic [NUM_OPS-1:0]         opnd_vector,
    input logic                       trap_now,
    input logic [1:0]                 reason_now,
    input logic                       trap_q,
    input logic [1:0]                 reason_q
);
    logic any_base;
    logic any_ext;
    logic any_base_vec;

    always_comb begin
        any_base     = 1'b0;
        any_ext      = 1'b0;
        any_base_vec = 1'b0;
        for (int i = 0; i < NUM_OPS; i++) begin
            if (opnd_valid[i]) begin
                if ((opnd_field[i*FIELD_W +: FIELD_W] >> BASE_W) != '0) begin
                    any_ext = 1'b1;
                end else begin
                    any_base = 1'b1;
                    if (opnd_vector[i]) any_base_vec = 1'b1;
                end
            end
        end
    end

    p_flag_matches_code_r7: assert property (@(posedge clk) disable iff (rst)
        trap_now == (reason_now != 2'b00));

    p_cross_groups_r2: assert property (@(posedge clk) disable iff (rst)
        (multi_class && any_base && any_ext) |-> reason_now == 2'b01);

    p_base_vector_r4: assert property (@(posedge clk) disable iff (rst)
        (!multi_class && any_base_vec) |-> reason_now == 2'b10);

    p_nothing_valid_r6: assert property (@(posedge clk) disable iff (rst)
        (opnd_valid == '0) |-> !trap_now);

    p_capture_r8: assert property (@(posedge clk) disable iff (rst)
        instr_valid |=> (trap_q == $past(trap_now) && reason_q == $past(reason_now)));

    p_idle_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> (!trap_q && reason_q == 2'b00));

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (!trap_q && reason_q == 2'b00));
endmodule

bind cf_group_check cf_group_check_sva #(
    .NUM_OPS (NUM_OPS),
    .FIELD_W (FIELD_W),
    .BASE_W  (BASE_W)
) u_sva (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .multi_class (multi_class),
    .opnd_valid  (opnd_valid),
    .opnd_field  (opnd_field),
    .opnd_vector (opnd_vector),
    .trap_now    (trap_now),
    .reason_now  (reason_now),
    .trap_q      (trap_q),
    .reason_q    (reason_q)
);

// File: tb/sim_cf_group_check.sv
`timescale 1ns/100ps
module sim_cf_group_check;
    localparam int N  = 3;
    localparam int FW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          instr_valid = 1'b0;
    logic          multi_class = 1'b0;
    logic [N-1:0]  opnd_valid  = '0;
    logic [N*FW-1:0] opnd_field = '0;
    logic [N-1:0]  opnd_vector = '0;
    logic          trap_now, trap_q;
    logic [1:0]    reason_now, reason_q;

    integer checks = 0;
    integer errors = 0;

    always #2.5 clk = ~clk;

    cf_group_check u0 (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .multi_class(multi_class),
        .opnd_valid(opnd_valid), .opnd_field(opnd_field), .opnd_vector(opnd_vector),
        .trap_now(trap_now), .reason_now(reason_now), .trap_q(trap_q), .reason_q(reason_q)
    );

    // Behavioural model of the verdict: base means field number below 8.
    function automatic int model_reason();
        bit saw_base = 0, saw_ext = 0, saw_bv = 0;
        for (int i = 0; i < N; i++) begin
            if (opnd_valid[i]) begin
                int f = int'(opnd_field[i*FW +: FW]);
                if (f >= 8) saw_ext = 1;
                else begin
                    saw_base = 1;
                    if (opnd_vector[i]) saw_bv = 1;
                end
            end
        end
        if (multi_class && saw_base && saw_ext) return 1;
        if (!multi_class && saw_bv) return 2;
        return 0;
    endfunction

    // Registered outputs: model latched at each rising edge, compared 2 ns later.
    always @(posedge clk) begin
        int exp_r;
        string tag;
        if (rst) begin exp_r = 0; tag = "R9"; end
        else if (instr_valid) begin exp_r = model_reason(); tag = "R8"; end
        else begin exp_r = 0; tag = "R8"; end
        #2;
        checks = checks + 1;
        if (trap_q !== (exp_r != 0) || reason_q !== 2'(exp_r)) begin
            errors = errors + 1;
            $display("FAIL %s registered: trap_q=%0b reason_q=%0d expected trap=%0b reason=%0d",
                     tag, trap_q, reason_q, exp_r != 0, exp_r);
        end
    end

    task automatic apply(input bit mc, input bit [2:0] v,
                         input int f0, input int f1, input int f2,
                         input bit [2:0] vec, input bit iv, input string tag);
        int exp_r;
        @(negedge clk);
        multi_class = mc;
        opnd_valid  = v;
        opnd_field  = {7'(f2), 7'(f1), 7'(f0)};
        opnd_vector = vec;
        instr_valid = iv;
        #1;
        exp_r = model_reason();
        checks = checks + 1;
        if (trap_now !== (exp_r != 0) || reason_now !== 2'(exp_r)) begin
            errors = errors + 1;
            $display("FAIL %s comb: trap_now=%0b reason_now=%0d expected trap=%0b reason=%0d",
                     tag, trap_now, reason_now, exp_r != 0, exp_r);
        end
    endtask

    initial begin
        #(200000 * 5);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R3: all-extended vectors 8,16,40 in a multi-operand op
        apply(1, 3'b111, 8, 16, 40, 3'b111, 1, "R3");
        // R2: scalar 7,9,10 crosses groups
        apply(1, 3'b111, 7, 9, 10, 3'b000, 1, "R2");
        // R3: base-only scalar multi-operand op
        apply(1, 3'b111, 0, 7, 3, 3'b000, 1, "R3");
        // R5: move field 40 into scalar field 5
        apply(0, 3'b011, 5, 40, 0, 3'b000, 1, "R5");
        // R5: splat field 40 onto vector starting at 16
        apply(0, 3'b011, 16, 40, 0, 3'b001, 1, "R5");
        // R4: splat onto vector starting at field 0
        apply(0, 3'b011, 0, 40, 0, 3'b001, 1, "R4");
        // R4: base vector as source
        apply(0, 3'b011, 20, 3, 0, 3'b010, 1, "R4");
        // R1: boundary 7 and 8 cross groups
        apply(1, 3'b011, 7, 8, 0, 3'b000, 1, "R1");
        // R1: 8 and 127 both extended
        apply(1, 3'b011, 8, 127, 0, 3'b000, 1, "R1");
        // R6: invalid base operand ignored in cross-over rule
        apply(1, 3'b110, 7, 9, 10, 3'b000, 1, "R6");
        // R6: invalid base vector ignored in single class
        apply(0, 3'b010, 0, 40, 0, 3'b001, 1, "R6");
        // R6: nothing valid never traps
        apply(1, 3'b000, 0, 64, 2, 3'b111, 1, "R6");
        // R7: cross-over in multi class with base vector present reports 01
        apply(1, 3'b111, 0, 9, 10, 3'b111, 1, "R7");
        // R8: strobe low with violating operands -> trap_q stays 0
        apply(1, 3'b111, 7, 9, 10, 3'b000, 0, "R8");
        apply(0, 3'b011, 0, 40, 0, 3'b001, 1, "R8");
        // R9: reset wins over strobe with violating operands
        @(negedge clk); rst = 1'b1;
        apply(0, 3'b011, 0, 40, 0, 3'b001, 1, "R9");
        @(negedge clk); rst = 1'b0;
        // R2 R4 R6 R8: mixed patterns
        for (int k = 0; k < 300; k++) begin
            int f0 = (k % 3 == 0) ? int'($urandom_range(0, 15)) : int'($urandom_range(0, 127));
            int f1 = int'($urandom_range(0, 15));
            int f2 = int'($urandom_range(0, 127));
            apply(bit'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), f0, f1, f2,
                  3'($urandom_range(0, 7)), bit'($urandom_range(0, 3) != 0), "R2/R4 mixed");
        end
        @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule